// File: doc/BRIEF.md
# Serial ADC Result Frame Reader

This block is the host side of a link to a serial-output data converter. On a start request it pulls chip select low and watches the converter's data line. While the converter is still converting, that line reads high. The reader keeps polling, with no clock pulses, until the line drops low. It then drives 24 serial clock pulses and samples the data line on every rising edge. The 24 bits are assembled most significant bit first.

The assembled frame has three status bits above a 21-bit result. The reader decodes the status bits into a sign flag, an over-range flag, an under-range flag and a framing-error flag. It presents these with the 21-bit result and a one-cycle valid strobe. The serial clock is the system clock divided by a run-time value. A polling timeout guards against a converter that never finishes. After every frame, chip select is held high for at least one full serial clock period.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, and result_valid and timeout are 0.
- R2: While the data line reads 1 after chip select falls, no sck pulse is issued. Polling ends on the first divider tick that samples a 0.
- R3: After the data line is seen low, exactly 24 rising sck edges occur. cs_n returns to 1 in the cycle result_valid is raised. sck is 0 whenever cs_n is 1.
- R4: result equals frame bits 20..0. Bit 23 is the first bit received and bit 0 is the last.
- R5: sign equals frame bit 21.
- R6: overrange is 1 exactly when bits 21 and 20 are both 1. underrange is 1 exactly when both are 0. The two flags are never 1 together.
- R7: frame_error is 1 when bit 22 or bit 23 of the captured frame was sampled as 1.
- R8: result_valid is a single-cycle pulse, raised once per completed frame.
- R9: Each sck high phase and each low phase lasts clk_div+1 system clock cycles.
- R10: In a read where the data line stays 1 for tmo_limit divider ticks, timeout pulses for one cycle. That pulse comes tmo_limit*(clk_div+1) cycles after cs_n fell. cs_n returns to 1, and no result_valid is produced.
- R11: Between frames, cs_n stays 1 for at least 2*(clk_div+1) system cycles, which is one sck period.
- R12: start is ignored while a read is in progress or while chip select is being held high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one frame read; acted on only when the reader is idle |
| clk_div | input | DIV_W | Each sck phase lasts clk_div+1 system cycles |
| tmo_limit | input | TMO_W | Number of polling ticks allowed before timeout |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock to the converter |
| result | output | 21 | Conversion result, bits 20..0 of the frame |
| sign | output | 1 | Frame bit 21 |
| overrange | output | 1 | Bits 21 and 20 both set |
| underrange | output | 1 | Bits 21 and 20 both clear |
| frame_error | output | 1 | Bit 22 or bit 23 captured high |
| result_valid | output | 1 | One-cycle strobe when the outputs above update |
| timeout | output | 1 | One-cycle strobe when polling gives up |

## Verification
A wrong bit counter or a slipped shift position shows up in two ways. The number of sck rising edges per frame changes, and the result word arrives shifted by a bit; both are visible on the first frame. A corrupted divider or phase register changes the measured sck high time on the very next pulse. A stuck polling counter moves the timeout pulse away from its exact expected cycle. A gap register that is wrong shortens the chip-select high time before the following frame.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

    localparam int FRAME_W = 24;
    localparam int RES_W   = 21;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_POLL  = 2'd1,
        RD_SHIFT = 2'd2,
        RD_GAP   = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic sign;
        logic over;
        logic under;
        logic ferr;
    } rd_status_t;

endpackage

// File: rtl/adc_rdr_tick.sv
module adc_rdr_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div);
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_rdr_shift.sv
module adc_rdr_shift
    import adc_rdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample,
    input  logic               sdo,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   count
);
    typedef struct packed {
        logic [FRAME_W-1:0] word;
        logic [CNT_W-1:0]   count;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (sample) begin
            sh_d.word  = {sh_q.word[FRAME_W-2:0], sdo};
            sh_d.count = sh_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word  = sh_q.word;
    assign count = sh_q.count;
endmodule

// File: rtl/adc_rdr_decode.sv
module adc_rdr_decode
    import adc_rdr_pkg::*;
(
    input  logic [FRAME_W-1:0] word,
    output logic [RES_W-1:0]   result,
    output rd_status_t         status
);
    logic sgn, msb;

    always_comb begin
        sgn          = word[RES_W];
        msb          = word[RES_W-1];
        result       = word[RES_W-1:0];
        status.sign  = sgn;
        status.over  = sgn & msb;
        status.under = ~sgn & ~msb;
        status.ferr  = word[RES_W+1] | word[RES_W+2];
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rdr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             sdo,
    output logic             cs_n,
    output logic             sck,
    output logic [20:0]      result,
    output logic             sign,
    output logic             overrange,
    output logic             underrange,
    output logic             frame_error,
    output logic             result_valid,
    output logic             timeout
);
    typedef struct packed {
        rd_state_e        st;
        logic             sck;
        logic             cs_n;
        logic [TMO_W-1:0] tmo_cnt;
        logic             gap_cnt;
        logic [RES_W-1:0] result;
        rd_status_t       stat;
        logic             valid;
        logic             tmo;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: RD_IDLE, sck: 1'b0, cs_n: 1'b1,
                                 tmo_cnt: '0, gap_cnt: 1'b0, result: '0,
                                 stat: '0, valid: 1'b0, tmo: 1'b0};

    ctl_t ctl_d, ctl_q;

    logic               tick;
    logic               sample;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   bit_cnt;
    logic [RES_W-1:0]   dec_result;
    rd_status_t         dec_stat;

    adc_rdr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctl_q.st != RD_IDLE),
        .div  (clk_div),
        .tick (tick)
    );

    assign sample = (ctl_q.st == RD_SHIFT) && tick && !ctl_q.sck;

    adc_rdr_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl_q.st == RD_IDLE),
        .sample(sample),
        .sdo   (sdo),
        .word  (word),
        .count (bit_cnt)
    );

    adc_rdr_decode u_dec (
        .word  (word),
        .result(dec_result),
        .status(dec_stat)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        ctl_d.tmo   = 1'b0;
        unique case (ctl_q.st)
            RD_IDLE: begin
                ctl_d.sck  = 1'b0;
                ctl_d.cs_n = 1'b1;
                if (start) begin
                    ctl_d.st      = RD_POLL;
                    ctl_d.cs_n    = 1'b0;
                    ctl_d.tmo_cnt = '0;
                end
            end
            RD_POLL: begin
                if (tick) begin
                    if (!sdo) begin
                        ctl_d.st = RD_SHIFT;
                    end else if (ctl_q.tmo_cnt == tmo_limit - 1'b1) begin
                        ctl_d.st      = RD_GAP;
                        ctl_d.cs_n    = 1'b1;
                        ctl_d.tmo     = 1'b1;
                        ctl_d.gap_cnt = 1'b0;
                    end else begin
                        ctl_d.tmo_cnt = ctl_q.tmo_cnt + 1'b1;
                    end
                end
            end
            RD_SHIFT: begin
                if (tick) begin
                    if (!ctl_q.sck) begin
                        ctl_d.sck = 1'b1;
                    end else begin
                        ctl_d.sck = 1'b0;
                        if (bit_cnt == CNT_W'(FRAME_W)) begin
                            ctl_d.st      = RD_GAP;
                            ctl_d.cs_n    = 1'b1;
                            ctl_d.valid   = 1'b1;
                            ctl_d.result  = dec_result;
                            ctl_d.stat    = dec_stat;
                            ctl_d.gap_cnt = 1'b0;
                        end
                    end
                end
            end
            RD_GAP: begin
                if (tick) begin
                    if (ctl_q.gap_cnt) ctl_d.st = RD_IDLE;
                    else               ctl_d.gap_cnt = 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign cs_n         = ctl_q.cs_n;
    assign sck          = ctl_q.sck;
    assign result       = ctl_q.result;
    assign sign         = ctl_q.stat.sign;
    assign overrange    = ctl_q.stat.over;
    assign underrange   = ctl_q.stat.under;
    assign frame_error  = ctl_q.stat.ferr;
    assign result_valid = ctl_q.valid;
    assign timeout      = ctl_q.tmo;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic sign,
    input logic overrange,
    input logic underrange,
    input logic result_valid,
    input logic timeout
);
    // R3: serial clock rests low whenever the converter is deselected
    p_sck_low_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R3: chip select is already high when the result is presented
    p_valid_cs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cs_n);

    // R8: valid strobe lasts one cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R6: range flags never both set
    p_range_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !(overrange && underrange));

    // R6: over-range implies positive sign, under-range implies negative
    p_range_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ((!overrange || sign) && (!underrange || !sign)));

    // R10: a timeout never coincides with a result and deselects the converter
    p_timeout_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!result_valid && cs_n));

    // R10: timeout strobe lasts one cycle
    p_timeout_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R11: chip select never pulses high for a single cycle
    p_cs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sck         (sck),
    .sign        (sign),
    .overrange   (overrange),
    .underrange  (underrange),
    .result_valid(result_valid),
    .timeout     (timeout)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;
    localparam int DIV_W = 4;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [TMO_W-1:0] tmo_limit = 8'hFF;
    logic             sdo;
    logic             cs_n, sck;
    logic [20:0]      result;
    logic             sign, overrange, underrange, frame_error;
    logic             result_valid, timeout;

    always #5 clk = ~clk;

    adc_frame_reader #(.DIV_W(DIV_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
        .tmo_limit(tmo_limit), .sdo(sdo), .cs_n(cs_n), .sck(sck),
        .result(result), .sign(sign), .overrange(overrange),
        .underrange(underrange), .frame_error(frame_error),
        .result_valid(result_valid), .timeout(timeout)
    );

    // converter model: busy until ready_at, then shifts frame out on falling sck
    int          cyc = 0;
    int          ready_at = 0;
    int          falls = 0;
    logic [23:0] frame = '0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge sck or posedge cs_n) begin
        if (cs_n) falls <= 0;
        else      falls <= falls + 1;
    end
    assign sdo = cs_n ? 1'b1 :
                 ((cyc < ready_at) || (falls >= 24)) ? 1'b1 : frame[23 - falls];

    // port monitors
    int  rises = 0, nvalid = 0;
    time t_rise = 0, hi_len = 0, t_csr = 0, t_csf = 0, gap = 0, t_to = 0;
    always @(posedge sck) begin rises <= rises + 1; t_rise = $time; end
    always @(negedge sck) hi_len = $time - t_rise;
    always @(posedge cs_n) t_csr = $time;
    always @(negedge cs_n) begin t_csf = $time; gap = $time - t_csr; end
    always @(posedge result_valid) nvalid <= nvalid + 1;
    always @(posedge timeout) t_to = $time;

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [23:0] w, input int delay, input bit chk_gap);
        int r0, n0, d;
        bit seen;
        d     = int'(clk_div) + 1;
        frame = w;
        @(negedge clk);
        ready_at = cyc + delay;
        r0 = rises;
        n0 = nvalid;
        start = 1'b1;
        for (int i = 0; i < 2000 && cs_n; i++) @(negedge clk);
        start = 1'b0;
        if (chk_gap) chk(gap >= time'(2 * d * 10), "R11 cs gap", gap, 2 * d * 10);
        seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (result_valid) seen = 1;
        end
        chk(seen, "R8 valid seen", seen, 1);
        chk(result == w[20:0], "R4 result", result, w[20:0]);
        chk(sign == w[21], "R5 sign", sign, w[21]);
        chk(overrange == (w[21] & w[20]), "R6 overrange", overrange, w[21] & w[20]);
        chk(underrange == (~w[21] & ~w[20]), "R6 underrange", underrange, ~w[21] & ~w[20]);
        chk(frame_error == (w[22] | w[23]), "R7 frame_error", frame_error, w[22] | w[23]);
        chk(rises - r0 == 24, "R2 R3 sck pulse count", rises - r0, 24);
        chk(cs_n == 1'b1, "R3 cs_n high at valid", cs_n, 1);
        chk(hi_len == time'(d * 10), "R9 sck high time", hi_len, d * 10);
        @(negedge clk);
        chk(result_valid == 1'b0, "R8 single pulse", result_valid, 0);
        chk(nvalid - n0 == 1, "R8 one valid per frame", nvalid - n0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sck == 1'b0, "R1 sck reset", sck, 0);
        chk(result_valid == 1'b0 && timeout == 1'b0, "R1 strobes reset",
            {result_valid, timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep over divider, status bits and result patterns
        foreach (clk_div_set[j]) ;
        for (int j = 0; j < 3; j++) begin
            clk_div = (j == 0) ? 4'd0 : (j == 1) ? 4'd1 : 4'd3;
            for (int s = 0; s < 8; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [19:0] lo;
                    logic [23:0] w;
                    lo = (k == 0) ? 20'h0 : (k == 3) ? 20'hFFFFF :
                         20'((k * 32'h5AAAB + s * 1237) & 32'hFFFFF);
                    w  = {1'b0, s[2], s[1], s[0], lo};
                    run_frame(w, 2 + (s + k) % 7 * (j + 1), !(s == 0 && k == 0));
                end
            end
            repeat (40) @(negedge clk);
        end

        // R10: converter never finishes
        begin
            int r0, n0;
            bit seen;
            clk_div   = 4'd1;
            tmo_limit = 8'd6;
            ready_at  = 32'h7FFFFFFF;
            r0 = rises;
            n0 = nvalid;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            seen = 0;
            for (int i = 0; i < 500 && !seen; i++) begin
                @(negedge clk);
                if (timeout) seen = 1;
            end
            chk(seen, "R10 timeout seen", seen, 1);
            chk(t_to - t_csf == time'(6 * 2 * 10), "R10 timeout latency", t_to - t_csf, 120);
            chk(cs_n == 1'b1, "R10 cs_n released", cs_n, 1);
            chk(rises == r0, "R2 no sck while polling", rises - r0, 0);
            repeat (50) @(negedge clk);
            chk(nvalid == n0, "R10 no result", nvalid - n0, 0);
            tmo_limit = 8'hFF;
            ready_at  = 0;
        end

        // R12: start pulsed mid-frame is ignored
        begin
            int n0;
            clk_div = 4'd2;
            frame   = 24'h3ABCDE;
            n0 = nvalid;
            @(negedge clk) begin ready_at = cyc + 10; start = 1'b1; end
            @(negedge clk) start = 1'b0;
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (400) @(negedge clk);
            chk(nvalid - n0 == 1, "R12 single frame", nvalid - n0, 1);
            chk(cs_n == 1'b1, "R12 stays deselected", cs_n, 1);
            chk(result == 21'h1ABCDE, "R12 result intact", result, 21'h1ABCDE);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    int clk_div_set[1];

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule